// File: doc/BRIEF.md
# Temperature Status Flags and Attention Arbiter

This block holds the three status flags of a single-wire bus temperature slave: conversion done, conversion overrun and bus error. It turns conversion-complete and bus-error events into an attention-request command for the line interface, and it paces temperature conversions from the configured rate.

The framing logic supplies strobes for register reads and writes, one strobe per bus bit seen, a bus-idle level, a bus-reset event and a report that an attention pulse was actually driven. The block exposes the status byte for readout, asks the line interface for an attention pulse, and sends a one-cycle start tick to the converter. The conversion period is counted in clock cycles, scaled by a cycles-per-millisecond parameter.

Top module: `status_attn`

## Requirements
- R1: The status byte has bus error in bit 7, overrun in bit 4 and conversion done in bit 0. Every other bit reads 0. The byte is 0x00 after reset.
- R2: A conversion-complete event sets bit 0 when bit 0 is clear. When bit 0 is already set, the event sets bit 4 instead.
- R3: A temperature-readout strobe clears bits 0 and 4. If a conversion-complete event arrives in the same cycle, bit 0 ends set and bit 4 ends clear.
- R4: A bus-error event sets bit 7. A status-read strobe clears bit 7, unless a bus-error event arrives in the same cycle, in which case bit 7 stays set.
- R5: A bus error requests attention once the bus is idle and the bit gate (R7) is open, even while an attention service is pending.
- R6: A conversion-complete event requests attention only if the attention-enable bit (temperature-control bit 0) is set and no attention is pending. Pending is set when the line interface reports an attention pulse was sent. It is cleared by a status read or a bus reset.
- R7: After power-on reset, bus reset or device reset, attn_req_o stays low until 14 bit strobes have been seen.
- R8: attn_req_o is low while the bus is not idle. A latched request is held until the line interface reports the pulse sent, and then drops.
- R9: Conversion starts are issued only while the function-enable bit (device-control bit 4) and the sensor-enable bit (temperature-control bit 1) are set and shutdown (device-control bit 1) is clear.
- R10: The start period is P = ms × TICKS_PER_MS cycles. For rate codes 00/01/10/11, ms is 64/96/190/382 with low power (device-control bit 2) clear and 96/382/766/1532 with it set. The first start comes P-1 cycles after the enabling write's clock edge, and later starts come every P cycles.
- R11: A device reset restores every default: flags clear, all enables and low power clear, rate code 10, nothing pending, no latched requests, bit gate re-armed. A device reset is either a device-control write with bit 0 set or the device-reset event. The reset bit is not stored.
- R12: A bus reset leaves the status flags unchanged. It clears pending and re-arms the bit gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| conv_done_i | input | 1 | Conversion-complete event |
| bus_err_i | input | 1 | Bus-error (negative acknowledge) event |
| rd_status_i | input | 1 | Status register read strobe |
| rd_temp_i | input | 1 | Temperature readout read strobe |
| wr_dev_ctrl_i | input | 1 | Device-control write strobe |
| wr_temp_ctrl_i | input | 1 | Temperature-control write strobe |
| wr_rate_i | input | 1 | Rate register write strobe |
| wr_data_i | input | 8 | Write data |
| bus_idle_i | input | 1 | Bus free for an attention pulse |
| bit_seen_i | input | 1 | One bus bit sent by the master |
| attn_sent_i | input | 1 | Line interface drove the attention pulse |
| bus_reset_i | input | 1 | Bus reset signal detected |
| dev_reset_i | input | 1 | Device reset event |
| status_o | output | 8 | Status byte |
| attn_req_o | output | 1 | Attention-request command |
| conv_start_o | output | 1 | Conversion-start tick |

## Verification
A wrong flag shows on status_o on the cycle after the event. A wrong pending or latched-request state shows on attn_req_o on that same next cycle, as a request that appears or fails to appear. A stale bit-gate count shows as attn_req_o rising one strobe early or late at the 14th bit. A wrong period choice or counter error is visible only at the next start tick, up to 1532 × TICKS_PER_MS cycles later. For that reason the bench measures both the first interval and a repeat interval.

// File: rtl/status_attn.sv
module status_attn #(
  parameter int TICKS_PER_MS = 1000,
  parameter int GATE_BITS    = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       conv_done_i,
  input  logic       bus_err_i,
  input  logic       rd_status_i,
  input  logic       rd_temp_i,
  input  logic       wr_dev_ctrl_i,
  input  logic       wr_temp_ctrl_i,
  input  logic       wr_rate_i,
  input  logic [7:0] wr_data_i,
  input  logic       bus_idle_i,
  input  logic       bit_seen_i,
  input  logic       attn_sent_i,
  input  logic       bus_reset_i,
  input  logic       dev_reset_i,
  output logic [7:0] status_o,
  output logic       attn_req_o,
  output logic       conv_start_o
);
  localparam int MAX_CYC = 1532 * TICKS_PER_MS;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam int GATE_W  = $clog2(GATE_BITS + 1);
  localparam logic [1:0] RATE_DEF = 2'b10;

  logic dev_rst;
  logic sf1, orun, ber;
  logic fn_en, low_pwr, shdn, sens_en, at_en;
  logic [1:0] rate;
  logic [GATE_W-1:0] gate_cnt;
  logic gate_open;
  logic ber_req, conv_req, pending;
  logic run;
  logic [CNT_W-1:0] cnt, period_last;
  logic [10:0] ms;

  assign dev_rst   = dev_reset_i | (wr_dev_ctrl_i & wr_data_i[0]);
  assign gate_open = (gate_cnt == GATE_W'(GATE_BITS));
  assign run       = fn_en & sens_en & ~shdn;
  assign status_o  = {ber, 2'b00, orun, 3'b000, sf1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sf1 <= 1'b0; orun <= 1'b0; ber <= 1'b0;
    end else if (dev_rst) begin
      sf1 <= 1'b0; orun <= 1'b0; ber <= 1'b0;
    end else begin
      if (conv_done_i)      sf1 <= 1'b1;
      else if (rd_temp_i)   sf1 <= 1'b0;
      if (rd_temp_i)                orun <= 1'b0;
      else if (conv_done_i && sf1)  orun <= 1'b1;
      if (bus_err_i)        ber <= 1'b1;
      else if (rd_status_i) ber <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fn_en <= 1'b0; low_pwr <= 1'b0; shdn <= 1'b0;
      sens_en <= 1'b0; at_en <= 1'b0; rate <= RATE_DEF;
    end else if (dev_rst) begin
      fn_en <= 1'b0; low_pwr <= 1'b0; shdn <= 1'b0;
      sens_en <= 1'b0; at_en <= 1'b0; rate <= RATE_DEF;
    end else begin
      if (wr_dev_ctrl_i) begin
        fn_en   <= wr_data_i[4];
        low_pwr <= wr_data_i[2];
        shdn    <= wr_data_i[1];
      end
      if (wr_temp_ctrl_i) begin
        sens_en <= wr_data_i[1];
        at_en   <= wr_data_i[0];
      end
      if (wr_rate_i) rate <= wr_data_i[1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      gate_cnt <= '0;
    else if (dev_rst || bus_reset_i) gate_cnt <= '0;
    else if (bit_seen_i && !gate_open) gate_cnt <= gate_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ber_req <= 1'b0; conv_req <= 1'b0; pending <= 1'b0;
    end else if (dev_rst) begin
      ber_req <= 1'b0; conv_req <= 1'b0; pending <= 1'b0;
    end else begin
      if (bus_err_i)        ber_req <= 1'b1;
      else if (attn_sent_i) ber_req <= 1'b0;
      if (attn_sent_i)                               conv_req <= 1'b0;
      else if (conv_done_i && at_en && !pending)     conv_req <= 1'b1;
      if (attn_sent_i)                      pending <= 1'b1;
      else if (rd_status_i || bus_reset_i)  pending <= 1'b0;
    end
  end

  assign attn_req_o = bus_idle_i & gate_open &
                      (ber_req | (conv_req & at_en & ~pending));

  always_comb begin
    case ({low_pwr, rate})
      3'b000:  ms = 11'd64;
      3'b001:  ms = 11'd96;
      3'b010:  ms = 11'd190;
      3'b011:  ms = 11'd382;
      3'b100:  ms = 11'd96;
      3'b101:  ms = 11'd382;
      3'b110:  ms = 11'd766;
      default: ms = 11'd1532;
    endcase
    period_last = CNT_W'(int'(ms) * TICKS_PER_MS - 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (!run || dev_rst)     cnt <= '0;
    else if (cnt >= period_last)  cnt <= '0;
    else                          cnt <= cnt + 1'b1;
  end

  assign conv_start_o = run & (cnt >= period_last);
endmodule

// File: rtl/status_attn_chk.sv
module status_attn_chk #(
  parameter int GATE_BITS = 14
) (
  input logic       clk,
  input logic       rst_n,
  input logic       conv_done_i,
  input logic       bus_err_i,
  input logic       rd_status_i,
  input logic       rd_temp_i,
  input logic       wr_dev_ctrl_i,
  input logic [7:0] wr_data_i,
  input logic       bus_idle_i,
  input logic       bit_seen_i,
  input logic       bus_reset_i,
  input logic       dev_reset_i,
  input logic [7:0] status_o,
  input logic       attn_req_o
);
  logic drst;
  int   bits_seen;
  assign drst = dev_reset_i | (wr_dev_ctrl_i & wr_data_i[0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    bits_seen <= 0;
    else if (drst || bus_reset_i)  bits_seen <= 0;
    else if (bit_seen_i && bits_seen < GATE_BITS) bits_seen <= bits_seen + 1;
  end

  // R1
  unused_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[6:5] == 2'b00 && status_o[3:1] == 3'b000);

  // R2
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done_i && status_o[0] && !rd_temp_i && !drst |=> status_o[4]);

  // R3
  temp_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_temp_i && !conv_done_i && !drst |=> !status_o[0] && !status_o[4]);

  // R4
  ber_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err_i && !drst |=> status_o[7]);

  // R7
  bit_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    attn_req_o |-> bits_seen >= GATE_BITS);

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_idle_i |-> !attn_req_o);

  // R11
  dev_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drst |=> status_o == 8'h00 && !attn_req_o);
endmodule

bind status_attn status_attn_chk #(.GATE_BITS(GATE_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .conv_done_i(conv_done_i), .bus_err_i(bus_err_i),
  .rd_status_i(rd_status_i), .rd_temp_i(rd_temp_i), .wr_dev_ctrl_i(wr_dev_ctrl_i),
  .wr_data_i(wr_data_i), .bus_idle_i(bus_idle_i), .bit_seen_i(bit_seen_i),
  .bus_reset_i(bus_reset_i), .dev_reset_i(dev_reset_i), .status_o(status_o),
  .attn_req_o(attn_req_o)
);

// File: tb/status_attn_bench.sv
module status_attn_bench;
  localparam int TPM = 2;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic conv_done_i = 0, bus_err_i = 0, rd_status_i = 0, rd_temp_i = 0;
  logic wr_dev_ctrl_i = 0, wr_temp_ctrl_i = 0, wr_rate_i = 0;
  logic [7:0] wr_data_i = '0;
  logic bus_idle_i = 1, bit_seen_i = 0, attn_sent_i = 0;
  logic bus_reset_i = 0, dev_reset_i = 0;
  logic [7:0] status_o;
  logic attn_req_o, conv_start_o;
  int n_run = 0, n_fail = 0, cycles = 0;

  always #2.5 clk = ~clk;

  status_attn #(.TICKS_PER_MS(TPM)) u_status_attn (.*);

  task automatic chk(input string req, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input int kind, input logic [7:0] d);
    wr_data_i = d;
    if (kind == 0) wr_dev_ctrl_i = 1; else if (kind == 1) wr_temp_ctrl_i = 1; else wr_rate_i = 1;
    cyc();
    wr_dev_ctrl_i = 0; wr_temp_ctrl_i = 0; wr_rate_i = 0; wr_data_i = '0;
  endtask

  task automatic conv();   conv_done_i = 1; cyc(); conv_done_i = 0; endtask
  task automatic berr();   bus_err_i = 1;   cyc(); bus_err_i = 0;   endtask
  task automatic rstat();  rd_status_i = 1; cyc(); rd_status_i = 0; endtask
  task automatic rtemp();  rd_temp_i = 1;   cyc(); rd_temp_i = 0;   endtask
  task automatic sent();   attn_sent_i = 1; cyc(); attn_sent_i = 0; endtask
  task automatic bits(input int k);
    for (int i = 0; i < k; i++) begin bit_seen_i = 1; cyc(); end
    bit_seen_i = 0;
  endtask

  task automatic t_reset();
    chk("R1", status_o, 8'h00);
    chk("R1", attn_req_o, 0);
    chk("R9", conv_start_o, 0);
  endtask

  task automatic t_gate();
    berr();
    chk("R4", status_o, 8'h80);
    chk("R7", attn_req_o, 0);
    bits(13);
    chk("R7", attn_req_o, 0);
    bits(1);
    chk("R7", attn_req_o, 1);
  endtask

  task automatic t_idle();
    bus_idle_i = 0; cyc();
    chk("R8", attn_req_o, 0);
    bus_idle_i = 1; cyc();
    chk("R8", attn_req_o, 1);
    sent();
    chk("R8", attn_req_o, 0);
  endtask

  task automatic t_ber_clear();
    rstat();
    chk("R4", status_o, 8'h00);
    bus_err_i = 1; rd_status_i = 1; cyc(); bus_err_i = 0; rd_status_i = 0;
    chk("R4", status_o, 8'h80);
    chk("R5", attn_req_o, 1);
    sent();
    rstat();
    chk("R4", status_o, 8'h00);
  endtask

  task automatic t_conv_flags();
    conv();
    chk("R2", status_o, 8'h01);
    chk("R6", attn_req_o, 0);
    conv();
    chk("R2", status_o, 8'h11);
    rtemp();
    chk("R3", status_o, 8'h00);
    conv_done_i = 1; rd_temp_i = 1; cyc(); conv_done_i = 0; rd_temp_i = 0;
    chk("R3", status_o, 8'h01);
    rtemp();
    chk("R3", status_o, 8'h00);
  endtask

  task automatic t_pending();
    wr(1, 8'h01);
    conv();
    chk("R6", attn_req_o, 1);
    sent();
    chk("R6", attn_req_o, 0);
    rtemp();
    conv();
    chk("R6", attn_req_o, 0);
    berr();
    chk("R5", attn_req_o, 1);
    sent();
    rstat();
    conv();
    chk("R2", status_o, 8'h11);
    chk("R6", attn_req_o, 1);
    sent();
  endtask

  task automatic t_bus_reset();
    bus_reset_i = 1; cyc(); bus_reset_i = 0;
    chk("R12", status_o, 8'h11);
    conv();
    chk("R12", attn_req_o, 0);
    bits(14);
    chk("R12", attn_req_o, 1);
    sent();
  endtask

  task automatic t_dev_reset();
    wr(2, 8'h03);
    wr(0, 8'h01);
    chk("R11", status_o, 8'h00);
    berr();
    chk("R11", attn_req_o, 0);
    bits(14);
    chk("R11", attn_req_o, 1);
    sent(); rstat();
    conv();
    chk("R11", attn_req_o, 0);
    rtemp();
  endtask

  task automatic meas_first(input int lim, output int n);
    n = 0;
    while (!conv_start_o && n < lim) begin @(negedge clk); n++; end
  endtask

  task automatic meas_next(input int lim, output int n);
    @(negedge clk); n = 1;
    while (!conv_start_o && n < lim) begin @(negedge clk); n++; end
  endtask

  task automatic t_pacing();
    int n;
    wr(1, 8'h02);
    wr(0, 8'h10);
    meas_first(5000, n);
    chk("R10", n, 190*TPM - 1);
    meas_next(5000, n);
    chk("R10", n, 190*TPM);
    wr(0, 8'h12);
    meas_first(3200, n);
    chk("R9", n, 3200);
    wr(0, 8'h00);
    wr(2, 8'h03);
    wr(0, 8'h14);
    meas_first(8000, n);
    chk("R10", n, 1532*TPM - 1);
    meas_next(8000, n);
    chk("R10", n, 1532*TPM);
    wr(0, 8'h00);
    wr(2, 8'h00);
    wr(0, 8'h10);
    meas_first(1000, n);
    chk("R10", n, 64*TPM - 1);
    wr(1, 8'h00);
    meas_first(1000, n);
    chk("R9", n, 1000);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got %0d cycles expected under 150000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_gate();
    t_idle();
    t_ber_clear();
    t_conv_flags();
    t_pending();
    t_bus_reset();
    t_dev_reset();
    t_pacing();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule